// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Sequencer

This block keeps the global interrupt enable and the halt (sleep) condition for a small in-order processor. The core reports each retired instruction with a strobe, plus one of four qualifiers: interrupts off, interrupts on (delayed), return-and-enable, and halt. It also reports each opcode fetch. From these strobes and two 5-bit registers, the per-source enable mask and the request flags, the block decides when a handler is entered.

On entry it produces a one-cycle dispatch pulse together with the handler address and a one-hot acknowledge. The acknowledge lets the flag register clear the serviced source. A halt can end in three ways:
- It sleeps and then enters a handler.
- It sleeps and then simply resumes.
- It does not sleep at all, but blocks the program-counter increment for the next fetch, so the byte after the halt is fetched twice.

The controller is a four-state machine:
- **RUN** is normal execution.
- **ARMED** means an enable instruction has retired and its effect is waiting for one more retirement.
- **SLEEP** means halted.
- **REFETCH** means the increment-block is waiting for its fetch.

The transitions are:
- *arm*: RUN/ARMED to ARMED on an enable retire.
- *settle*: ARMED to RUN on any other retire.
- *cancel*: ARMED to RUN on a disable retire.
- *doze*: RUN/ARMED to SLEEP on a halt retire when the enable is in effect or nothing is pending.
- *glitch*: RUN/ARMED to REFETCH on a halt retire with the enable off and a request pending.
- *wake*: SLEEP to RUN once a request is pending.
- *release*: REFETCH to RUN on a fetch strobe.
- *take*: to RUN with the enable cleared on any dispatch.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, `ime_o`, `halted_o`, `pc_hold_o` and `dispatch_req_o` are 0 and `irq_ack_o` is 0.
- R2: A retire with `op_di` drives `ime_o` to 0 on that clock edge, and no dispatch follows that boundary.
- R3: A retire with `op_ei` leaves `ime_o` unchanged. `ime_o` becomes 1 on the edge where the next instruction retires. No dispatch is made at the enabling instruction's own boundary, even with a request pending.
- R4: A retire with `op_reti` drives `ime_o` to 1 on that same edge. A request already pending is dispatched at that boundary.
- R5: A request is pending when `irq_en & irq_flag` is nonzero. A dispatch happens at a retire boundary where the enable is in effect. When several requests are pending, the lowest bit n wins. The dispatch is a one-cycle `dispatch_req_o`, with `dispatch_vec_o` = 0x40 + 8*n, `irq_ack_o` = 1<<n, and `ime_o` cleared in the same cycle.
- R6: A halt retired with the enable in effect raises `halted_o` and holds it while nothing is pending. On the edge after a request becomes pending, `halted_o` falls and the handler is dispatched.
- R7: A halt retired with the enable off and nothing pending raises `halted_o`. When a request becomes pending, `halted_o` falls on the next edge with no dispatch and no acknowledge.
- R8: A halt retired with the enable off and a request pending leaves `halted_o` at 0 and raises `pc_hold_o`. `pc_hold_o` stays high up to and including the first cycle with `fetch_strb`, and falls on that edge.
- R9: A disable retired while an enable is still waiting cancels it: `ime_o` stays 0 after later retires.
- R10: A halt that retires right after an enable instruction counts as halting with the enable in effect. It sleeps, `ime_o` reads 1, and a later request is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | An instruction retired this cycle |
| op_di | input | 1 | Retiring instruction disables interrupts |
| op_ei | input | 1 | Retiring instruction enables interrupts after one more instruction |
| op_reti | input | 1 | Retiring instruction returns and enables at once |
| op_halt | input | 1 | Retiring instruction is a halt |
| fetch_strb | input | 1 | Opcode fetch in this cycle |
| irq_en | input | 5 | Per-source enable mask |
| irq_flag | input | 5 | Per-source request flags |
| ime_o | output | 1 | Master enable in effect |
| halted_o | output | 1 | Core is sleeping |
| pc_hold_o | output | 1 | Block the program-counter increment on the next fetch |
| dispatch_req_o | output | 1 | One-cycle handler entry pulse |
| dispatch_vec_o | output | 16 | Handler address |
| irq_ack_o | output | 5 | One-hot clear for the serviced flag |

## Verification
The properties assume the following about the inputs:
- At most one qualifier is high, and only together with `insn_done`.
- No instruction retires while the core sleeps.
- No instruction retires in the increment-block window before its fetch.

The stimulus drives each retirement as a single-cycle strobe with a single qualifier, and only between sleep exits and fetch releases. The bench issues the fetch strobe explicitly to close the refetch window. The flag and mask patterns change only between boundaries, so each one is held steady across the edge that samples it.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_REFETCH = 2'd3
    } ctl_state_t;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N          = 5,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 64,
    parameter int VEC_STRIDE = 8
) (
    input  logic [N-1:0]     en_i,
    input  logic [N-1:0]     flag_i,
    output logic             any_o,
    output logic [N-1:0]     sel_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     req;
    logic [IDX_W-1:0] idx;

    assign req   = en_i & flag_i;
    assign any_o = |req;

    // one-hot of the lowest pending source
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_sel
            if (g == 0) begin : g_first
                assign sel_o[g] = req[g];
            end else begin : g_rest
                assign sel_o[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign vec_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(idx);

endmodule

// File: rtl/irq_dispatch_out.sv
module irq_dispatch_out #(
    parameter int N     = 5,
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [N-1:0]     sel_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N-1:0]     ack_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            vec_o <= '0;
            ack_o <= '0;
        end else begin
            req_o <= fire_i;
            ack_o <= fire_i ? sel_i : '0;
            if (fire_i) vec_o <= vec_i;
        end
    end
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
    parameter int N_SRC      = 5,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 64,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             op_di,
    input  logic             op_ei,
    input  logic             op_reti,
    input  logic             op_halt,
    input  logic             fetch_strb,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_flag,
    output logic             ime_o,
    output logic             halted_o,
    output logic             pc_hold_o,
    output logic             dispatch_req_o,
    output logic [VEC_W-1:0] dispatch_vec_o,
    output logic [N_SRC-1:0] irq_ack_o
);
    import irq_halt_pkg::*;

    ctl_state_t       st_q, st_n;
    logic             ime_q, ime_n;
    logic             take;
    logic             pend;
    logic [N_SRC-1:0] pick_sel;
    logic [VEC_W-1:0] pick_vec;

    irq_pick #(
        .N(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_pick (
        .en_i(irq_en), .flag_i(irq_flag),
        .any_o(pend), .sel_o(pick_sel), .vec_o(pick_vec)
    );

    irq_dispatch_out #(.N(N_SRC), .VEC_W(VEC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .fire_i(take),
        .sel_i(pick_sel), .vec_i(pick_vec),
        .req_o(dispatch_req_o), .vec_o(dispatch_vec_o), .ack_o(irq_ack_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            ime_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            ime_q <= ime_n;
        end
    end

    // next state
    always_comb begin
        logic armed;
        armed = (st_q == ST_ARMED);
        st_n  = st_q;
        ime_n = ime_q;
        take  = 1'b0;
        unique case (st_q)
            ST_RUN, ST_ARMED: begin
                if (insn_done) begin
                    if (op_di) begin            // cancel
                        ime_n = 1'b0;
                        st_n  = ST_RUN;
                    end else if (op_reti) begin
                        ime_n = 1'b1;
                        st_n  = ST_RUN;
                    end else if (op_ei) begin   // arm
                        ime_n = ime_q | armed;
                        st_n  = ST_ARMED;
                    end else if (op_halt) begin // doze or glitch
                        ime_n = ime_q | armed;
                        st_n  = (ime_n || !pend) ? ST_SLEEP : ST_REFETCH;
                    end else begin              // settle
                        ime_n = ime_q | armed;
                        st_n  = ST_RUN;
                    end
                    if (!op_halt && ime_n && pend) begin // take
                        take  = 1'b1;
                        ime_n = 1'b0;
                        st_n  = ST_RUN;
                    end
                end
            end
            ST_SLEEP: begin
                if (pend) begin                 // wake
                    st_n = ST_RUN;
                    if (ime_q) begin
                        take  = 1'b1;
                        ime_n = 1'b0;
                    end
                end
            end
            ST_REFETCH: begin
                if (fetch_strb) st_n = ST_RUN;  // release
            end
        endcase
    end

    // outputs
    always_comb begin
        ime_o     = ime_q;
        halted_o  = (st_q == ST_SLEEP);
        pc_hold_o = (st_q == ST_REFETCH);
    end

endmodule

// File: rtl/irq_halt_chk.sv
module irq_halt_chk #(
    parameter int N_SRC = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_done,
    input logic             op_di,
    input logic             op_ei,
    input logic             op_reti,
    input logic             fetch_strb,
    input logic [1:0]       st_q,
    input logic             ime_o,
    input logic             halted_o,
    input logic             pc_hold_o,
    input logic             dispatch_req_o,
    input logic [N_SRC-1:0] irq_ack_o
);
    logic awake;
    assign awake = !halted_o && !pc_hold_o;

    // R2
    di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && op_di && awake) |=> (!ime_o && !dispatch_req_o));

    // R3
    ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && op_ei && !ime_o && awake && st_q != 2'd1) |=> (!ime_o && !dispatch_req_o));

    // R4
    reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && op_reti && awake) |=> (ime_o || dispatch_req_o));

    // R5
    dispatch_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_req_o |-> ($onehot(irq_ack_o) && !ime_o));

    // R5
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dispatch_req_o |-> (irq_ack_o == '0));

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold_o && fetch_strb) |=> !pc_hold_o);

    // R6
    sleep_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !pc_hold_o);
endmodule

bind irq_halt_ctrl irq_halt_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .op_di(op_di),
    .op_ei(op_ei), .op_reti(op_reti), .fetch_strb(fetch_strb),
    .st_q(st_q), .ime_o(ime_o), .halted_o(halted_o), .pc_hold_o(pc_hold_o),
    .dispatch_req_o(dispatch_req_o), .irq_ack_o(irq_ack_o)
);

// File: tb/sim_irq_halt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_halt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, op_di = 1'b0, op_ei = 1'b0, op_reti = 1'b0, op_halt = 1'b0;
    logic        fetch_strb = 1'b0;
    logic [4:0]  ie = 5'h1F, fl = 5'h00;
    logic        ime_o, halted_o, pc_hold_o, dispatch_req_o;
    logic [15:0] dispatch_vec_o;
    logic [4:0]  irq_ack_o;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_halt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .op_di(op_di),
        .op_ei(op_ei), .op_reti(op_reti), .op_halt(op_halt),
        .fetch_strb(fetch_strb), .irq_en(ie), .irq_flag(fl),
        .ime_o(ime_o), .halted_o(halted_o), .pc_hold_o(pc_hold_o),
        .dispatch_req_o(dispatch_req_o), .dispatch_vec_o(dispatch_vec_o),
        .irq_ack_o(irq_ack_o)
    );

    // behavioural reference: mode 0 run, 1 asleep, 2 refetch window
    int m_ime, m_wait, m_mode, e_req, e_vec, e_ack;
    always @(posedge clk or negedge rst_n) begin
        int lo, en_after;
        if (!rst_n) begin
            m_ime = 0; m_wait = 0; m_mode = 0; e_req = 0; e_vec = 0; e_ack = 0;
        end else begin
            lo = -1;
            for (int i = 4; i >= 0; i--) if (ie[i] && fl[i]) lo = i;
            e_req = 0; e_ack = 0;
            if (m_mode == 1) begin
                if (lo >= 0) begin
                    m_mode = 0;
                    if (m_ime != 0) begin
                        e_req = 1; e_vec = 64 + 8 * lo; e_ack = 1 << lo; m_ime = 0;
                    end
                end
            end else if (m_mode == 2) begin
                if (fetch_strb) m_mode = 0;
            end else if (insn_done) begin
                en_after = (m_ime != 0 || m_wait != 0) ? 1 : 0;
                if (op_di) begin m_ime = 0; m_wait = 0; end
                else if (op_reti) begin m_ime = 1; m_wait = 0; end
                else if (op_ei) begin m_ime = en_after; m_wait = 1; end
                else if (op_halt) begin
                    m_ime = en_after; m_wait = 0;
                    m_mode = (en_after != 0 || lo < 0) ? 1 : 2;
                end else begin m_ime = en_after; m_wait = 0; end
                if (!op_halt && m_ime != 0 && lo >= 0) begin
                    e_req = 1; e_vec = 64 + 8 * lo; e_ack = 1 << lo;
                    m_ime = 0; m_wait = 0;
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (ime_o !== (m_ime != 0) || halted_o !== (m_mode == 1) ||
                pc_hold_o !== (m_mode == 2) || dispatch_req_o !== (e_req != 0) ||
                irq_ack_o !== 5'(e_ack) || (e_req != 0 && dispatch_vec_o !== 16'(e_vec))) begin
                fails++;
                $display("FAIL R2 R3 R4 R5 R6 R7 R8 model: act ime=%0d hlt=%0d hold=%0d req=%0d vec=%h ack=%b exp ime=%0d mode=%0d req=%0d vec=%h ack=%b",
                    ime_o, halted_o, pc_hold_o, dispatch_req_o, dispatch_vec_o, irq_ack_o,
                    m_ime, m_mode, e_req, e_vec, 5'(e_ack));
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // kind: 0 plain, 1 di, 2 ei, 3 reti, 4 halt
    task automatic retire(int kind);
        insn_done = 1'b1;
        op_di = (kind == 1); op_ei = (kind == 2); op_reti = (kind == 3); op_halt = (kind == 4);
        @(negedge clk);
        insn_done = 1'b0; op_di = 1'b0; op_ei = 1'b0; op_reti = 1'b0; op_halt = 1'b0;
    endtask

    task automatic set_irq(logic [4:0] e, logic [4:0] f);
        ie = e; fl = f;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ime", ime_o, 0); chk("R1 halted", halted_o, 0);
        chk("R1 hold", pc_hold_o, 0); chk("R1 req", dispatch_req_o, 0);
        chk("R1 ack", irq_ack_o, 0);

        retire(3); chk("R4 reti sets ime", ime_o, 1);
        retire(1); chk("R2 di clears ime", ime_o, 0);

        retire(2); chk("R3 ime after ei", ime_o, 0);
        retire(0); chk("R3 ime after next", ime_o, 1);
        retire(1);

        retire(2); retire(1); retire(0); retire(0);
        chk("R9 cancelled ei", ime_o, 0);

        set_irq(5'b11101, 5'b00010);
        retire(3); chk("R5 masked no dispatch", dispatch_req_o, 0);
        chk("R5 masked ime", ime_o, 1);
        set_irq(5'b11111, 5'b11010);
        retire(0); chk("R5 priority req", dispatch_req_o, 1);
        chk("R5 priority vec", dispatch_vec_o, 16'h48);
        chk("R5 priority ack", irq_ack_o, 5'b00010);
        chk("R5 ime cleared", ime_o, 0);
        set_irq(5'h1F, 5'h00);

        set_irq(5'h1F, 5'b00100);
        retire(3); chk("R4 immediate dispatch", dispatch_req_o, 1);
        chk("R4 vec", dispatch_vec_o, 16'h50);
        set_irq(5'h1F, 5'b10000);
        retire(3); chk("R5 top source vec", dispatch_vec_o, 16'h60);
        chk("R5 top source ack", irq_ack_o, 5'b10000);
        step(1); chk("R5 one-cycle pulse", dispatch_req_o, 0);
        set_irq(5'h1F, 5'h00);

        set_irq(5'h1F, 5'b00001);
        retire(2); chk("R3 no dispatch at ei", dispatch_req_o, 0);
        retire(0); chk("R3 dispatch after next", dispatch_req_o, 1);
        chk("R3 vec", dispatch_vec_o, 16'h40);
        set_irq(5'h1F, 5'h00);

        retire(3);
        retire(4); chk("R6 sleeping", halted_o, 1);
        step(3); chk("R6 still sleeping", halted_o, 1);
        set_irq(5'h1F, 5'b01000); step(1);
        chk("R6 woke", halted_o, 0); chk("R6 dispatch", dispatch_req_o, 1);
        chk("R6 vec", dispatch_vec_o, 16'h58);
        set_irq(5'h1F, 5'h00);

        retire(4); chk("R7 sleeping", halted_o, 1);
        set_irq(5'b11011, 5'b00100); step(2); chk("R7 masked stays", halted_o, 1);
        set_irq(5'h1F, 5'b00100); step(1);
        chk("R7 woke", halted_o, 0); chk("R7 no dispatch", dispatch_req_o, 0);
        chk("R7 no ack", irq_ack_o, 0);
        set_irq(5'h1F, 5'h00);

        set_irq(5'h1F, 5'b00001);
        retire(4); chk("R8 not halted", halted_o, 0); chk("R8 hold", pc_hold_o, 1);
        step(2); chk("R8 hold kept", pc_hold_o, 1);
        fetch_strb = 1'b1; chk("R8 hold during fetch", pc_hold_o, 1);
        @(negedge clk); fetch_strb = 1'b0;
        chk("R8 hold released", pc_hold_o, 0);
        chk("R8 no dispatch", dispatch_req_o, 0);
        set_irq(5'h1F, 5'h00);

        retire(2); retire(4);
        chk("R10 sleeping", halted_o, 1); chk("R10 ime", ime_o, 1);
        set_irq(5'h1F, 5'b00010); step(1);
        chk("R10 dispatch", dispatch_req_o, 1); chk("R10 vec", dispatch_vec_o, 16'h48);
        set_irq(5'h1F, 5'h00);

        retire(3); set_irq(5'h1F, 5'b00001);
        retire(1); chk("R2 no dispatch at di", dispatch_req_o, 0);
        chk("R2 ime", ime_o, 0);
        set_irq(5'h1F, 5'h00);
        step(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule